// File: doc/BRIEF.md
# Three-Operand Integer Adder

This execution unit produces one 32-bit integer sum from three source operands. A 64-bit instruction word carries the controls. Each operand can be narrowed to one of its 16-bit halves and then negated. A combine rule decides whether the partial sum of the first two operands is shifted by 16 bits, in either direction, before the third operand is added. A form tag says whether the operands came from registers, from a constant bank or from an immediate. Only the register form applies the half-word selects and the shift rules.

Operands and the instruction are presented together with an input valid. The result, and an illegal-encoding flag, appear one clock later with an output valid. When no new request arrives, the result and the flag hold their last values. Fetching the operands, condition codes, carry-out and saturation all belong to the surrounding pipeline.

Top module: `tri_add_unit`

## Requirements
- R1: An active-low synchronous reset clears `out_valid`, `result` and `illegal`, even while `in_valid` is high.
- R2: `out_valid` equals `in_valid` delayed by one clock. `result` and `illegal` are captured when `in_valid` is high and hold their values while it is low.
- R3: Half-word select fields are instruction bits [36:35] for A, [34:33] for B and [32:31] for C. Code 0 passes the full operand, code 1 keeps the low 16 bits with the upper bits zeroed, and code 2 gives the operand logically shifted right by 16.
- R4: Negate flags are bit 51 for A, bit 50 for B and bit 49 for C. A set flag replaces the operand by its two's-complement negation, taken after the half-word selection.
- R5: The combine field is bits [38:37]. Code 0 gives A+B+C, code 1 gives ((A+B)>>16)+C and code 2 gives ((A+B)<<16)+C.
- R6: In combine code 1, A+B is formed with 33 bits, keeping the carry, and the shift is logical. A carry out of A+B therefore lands in bit 16 of the shifted value.
- R7: Form code 0 is the register form. Codes 1 (constant) and 2 (immediate) ignore the half-word and combine fields: they compute a plain A+B+C with negation still applied, and they never raise `illegal`.
- R8: In the register form, code 3 in any half-word field or in the combine field sets `illegal`, and that field is treated as code 0.
- R9: All other arithmetic wraps modulo 2^32, and the result is truncated to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 64 | Instruction word holding the selects, negate flags and combine rule |
| form | input | 2 | Operand form: 0 register, 1 constant, 2 immediate |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_c | input | 32 | Operand C |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | 32 | Registered sum |
| illegal | output | 1 | Reserved encoding seen in the register form |

## Verification
Two functions often act in the same cycle: narrowing and negating each operand, and the combine rule that shifts the partial sum. A reserved code can also arrive in one field while another field holds a legal value. The bench provokes these overlaps with a vector table and with a sweep over every pair of half-word codes and combine codes, with random negate flags and random operands. Each result is judged against an independent 64-bit reference model. Directed cases cover a carry out of A+B under the right shift, and negation of zero.

// File: rtl/tri_add_pkg.sv
`timescale 1ns/1ps
package tri_add_pkg;

    typedef enum logic [1:0] {
        HSEL_FULL = 2'd0,
        HSEL_LOW  = 2'd1,
        HSEL_HIGH = 2'd2,
        HSEL_RSVD = 2'd3
    } hsel_e;

    typedef enum logic [1:0] {
        CMB_SUM  = 2'd0,
        CMB_SHR  = 2'd1,
        CMB_SHL  = 2'd2,
        CMB_RSVD = 2'd3
    } cmb_e;

    typedef enum logic [1:0] {
        FORM_REG   = 2'd0,
        FORM_CONST = 2'd1,
        FORM_IMM   = 2'd2,
        FORM_RSVD  = 2'd3
    } form_e;

    localparam int NUM_OPS   = 3;
    localparam int INSTR_W   = 64;
    // operand index 0 = A, 1 = B, 2 = C
    localparam int HSEL_A_LSB = 35;   // B at 33, C at 31
    localparam int NEG_A_BIT  = 51;   // B at 50, C at 49
    localparam int CMB_LSB    = 37;

    typedef struct packed {
        hsel_e [NUM_OPS-1:0] hsel;
        logic  [NUM_OPS-1:0] neg;
        cmb_e                mode;
        logic                illegal;
    } ctl_t;

endpackage

// File: rtl/tri_add_decode.sv
`timescale 1ns/1ps
module tri_add_decode
    import tri_add_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic [1:0]         form,
    output ctl_t               ctl
);
    logic       reg_form;
    logic [1:0] raw_mode;

    assign reg_form = (form == FORM_REG);
    assign raw_mode = instr[CMB_LSB +: 2];

    always_comb begin
        ctl = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            logic [1:0] raw_h;
            raw_h      = instr[HSEL_A_LSB - 2*k +: 2];
            ctl.neg[k] = instr[NEG_A_BIT - k];
            if (!reg_form || raw_h == HSEL_RSVD) begin
                ctl.hsel[k] = HSEL_FULL;
            end else begin
                ctl.hsel[k] = hsel_e'(raw_h);
            end
            if (reg_form && raw_h == HSEL_RSVD) begin
                ctl.illegal = 1'b1;
            end
        end
        if (!reg_form || raw_mode == CMB_RSVD) begin
            ctl.mode = CMB_SUM;
        end else begin
            ctl.mode = cmb_e'(raw_mode);
        end
        if (reg_form && raw_mode == CMB_RSVD) begin
            ctl.illegal = 1'b1;
        end
    end

    // Non-register forms must reduce to a plain sum with no illegal flag.
    always_comb begin
        if (!reg_form) begin
            assert_plain_form_R7: assert (ctl.mode == CMB_SUM && !ctl.illegal &&
                                          ctl.hsel == '0);
        end
    end

endmodule

// File: rtl/tri_add_opnd.sv
`timescale 1ns/1ps
module tri_add_opnd
    import tri_add_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  hsel_e        hsel,
    input  logic         neg,
    output logic [W-1:0] eff
);
    localparam int HALF = W / 2;

    logic [W-1:0] narrowed;

    always_comb begin
        unique case (hsel)
            HSEL_LOW:  narrowed = {{(W-HALF){1'b0}}, val[HALF-1:0]};
            HSEL_HIGH: narrowed = val >> HALF;
            default:   narrowed = val;
        endcase
        eff = neg ? (~narrowed + 1'b1) : narrowed;
    end

    always_comb begin
        if (!neg && hsel != HSEL_FULL) begin
            assert_half_top_clear_R3: assert (eff[W-1:HALF] == '0);
        end
        if (neg && val == '0) begin
            assert_neg_zero_R4: assert (eff == '0);
        end
    end

endmodule

// File: rtl/tri_add_combine.sv
`timescale 1ns/1ps
module tri_add_combine
    import tri_add_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  cmb_e         mode,
    output logic [W-1:0] sum
);
    localparam int SH = W / 2;

    logic [W:0]   ab_wide;
    logic [W:0]   ab_shr;
    logic [W-1:0] ab_shl;

    always_comb begin
        ab_wide = {1'b0, a} + {1'b0, b};
        ab_shr  = ab_wide >> SH;
        ab_shl  = ab_wide[W-1:0] << SH;
        unique case (mode)
            CMB_SHR: sum = ab_shr[W-1:0] + c;
            CMB_SHL: sum = ab_shl + c;
            default: sum = ab_wide[W-1:0] + c;
        endcase
    end

    always_comb begin
        if (mode == CMB_SHL) begin
            assert_shl_low_clear_R5: assert (((sum - c) & ((W'(1) << SH) - 1'b1)) == '0);
        end
        if (mode == CMB_SHR) begin
            assert_shr_range_R6: assert ((sum - c) <= W'((W'(1) << (SH + 1)) - 1'b1));
        end
    end

endmodule

// File: rtl/tri_add_unit.sv
`timescale 1ns/1ps
module tri_add_unit
    import tri_add_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [1:0]         form,
    input  logic [W-1:0]       op_a,
    input  logic [W-1:0]       op_b,
    input  logic [W-1:0]       op_c,
    output logic               out_valid,
    output logic [W-1:0]       result,
    output logic               illegal
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] result;
        logic         illegal;
    } state_t;

    state_t       st_d, st_q;
    ctl_t         ctl;
    logic [W-1:0] raw_op [NUM_OPS];
    logic [W-1:0] eff_op [NUM_OPS];
    logic [W-1:0] sum;

    assign raw_op[0] = op_a;
    assign raw_op[1] = op_b;
    assign raw_op[2] = op_c;

    tri_add_decode u_decode (
        .instr (instr),
        .form  (form),
        .ctl   (ctl)
    );

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_opnd
        tri_add_opnd #(.W(W)) u_opnd (
            .val  (raw_op[k]),
            .hsel (ctl.hsel[k]),
            .neg  (ctl.neg[k]),
            .eff  (eff_op[k])
        );
    end

    tri_add_combine #(.W(W)) u_combine (
        .a    (eff_op[0]),
        .b    (eff_op[1]),
        .c    (eff_op[2]),
        .mode (ctl.mode),
        .sum  (sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result  = sum;
            st_d.illegal = ctl.illegal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign illegal   = st_q.illegal;

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    assert_plain_no_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && form != FORM_REG) |=> !illegal);

endmodule

// File: tb/tri_add_unit_tb.sv
`timescale 1ns/1ps
module tri_add_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] instr = '0;
    logic [1:0]  form = '0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        illegal;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tri_add_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .form(form),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    typedef struct packed {
        logic [1:0]  fm;
        logic [1:0]  ha, hb, hc, md;
        logic        na, nb, nc;
        logic [31:0] a, b, c;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'd10, 32'd20, 32'd30},
        '{2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 32'd1},
        '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1, 32'd0},
        '{2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0001_2345, 32'd1, 32'd7},
        '{2'd0, 2'd2, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 32'h8000_0000, 32'd5, 32'hABCD_0003},
        '{2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'hFFFF_0001, 32'd2, 32'd3},
        '{2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 32'd100, 32'd40, 32'd2},
        '{2'd0, 2'd3, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF_0000, 32'h0001_0000, 32'd9},
        '{2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 32'd1, 32'd2, 32'd3},
        '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5}
    };

    function automatic logic [63:0] mk_instr(logic [1:0] ha, logic [1:0] hb, logic [1:0] hc,
                                             logic [1:0] md, logic na, logic nb, logic nc);
        logic [63:0] w = '0;
        w[36:35] = ha; w[34:33] = hb; w[32:31] = hc; w[38:37] = md;
        w[51] = na; w[50] = nb; w[49] = nc;
        return w;
    endfunction

    function automatic longint unsigned pick(longint unsigned v, int h, logic n);
        longint unsigned r = v;
        if (h == 1) r = v % 65536;
        else if (h == 2) r = v / 65536;
        if (n) r = (64'h1_0000_0000 - r) % 64'h1_0000_0000;
        return r;
    endfunction

    function automatic logic [31:0] model(vec_t v);
        int ha = v.ha, hb = v.hb, hc = v.hc, md = v.md;
        longint unsigned a, b, c, s;
        if (v.fm != 2'd0) begin ha = 0; hb = 0; hc = 0; md = 0; end
        if (ha == 3) ha = 0;
        if (hb == 3) hb = 0;
        if (hc == 3) hc = 0;
        if (md == 3) md = 0;
        a = pick(v.a, ha, v.na);
        b = pick(v.b, hb, v.nb);
        c = pick(v.c, hc, v.nc);
        s = a + b;
        if (md == 1) s = s / 65536;
        else if (md == 2) s = (s % 64'h1_0000_0000) * 65536;
        return 32'((s + c) % 64'h1_0000_0000);
    endfunction

    function automatic logic model_ill(vec_t v);
        return (v.fm == 2'd0) && (v.ha == 2'd3 || v.hb == 2'd3 || v.hc == 2'd3 || v.md == 2'd3);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(vec_t v, string req);
        @(negedge clk);
        instr = mk_instr(v.ha, v.hb, v.hc, v.md, v.na, v.nb, v.nc);
        form = v.fm; op_a = v.a; op_b = v.b; op_c = v.c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " result"}, result, model(v));
        check({req, " illegal R8"}, {31'd0, illegal}, {31'd0, model_ill(v)});
        check("R2 out_valid", {31'd0, out_valid}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("[TB] FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t v;
        logic [31:0] held;
        // R1: reset holds everything clear even with a request pending
        in_valid = 1'b1;
        op_a = 32'd1;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 result in reset", result, 32'd0);
        check("R1 illegal in reset", {31'd0, illegal}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], "R3 R4 R5 R7 R9 table");

        // sweep every select/mode pairing in every form
        for (int f = 0; f < 3; f++)
            for (int s = 0; s < 256; s++) begin
                v.fm = 2'(f);
                v.ha = 2'(s >> 6); v.hb = 2'(s >> 4); v.hc = 2'(s >> 2); v.md = 2'(s);
                v.na = 1'($urandom); v.nb = 1'($urandom); v.nc = 1'($urandom);
                v.a = $urandom; v.b = $urandom; v.c = $urandom;
                run_vec(v, "R3 R4 R5 R6 R7 R8 sweep");
            end

        // R6: carry out of A+B reaches bit 16
        v = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1, 32'd0};
        run_vec(v, "R6 carry");
        check("R6 carry literal", result, 32'h0001_0000);
        // R6: logical shift of a large sum
        v = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'd3};
        run_vec(v, "R6 logical");
        check("R6 logical literal", result, 32'h0001_0003);
        // R4: negation of zero, after narrowing a value whose low half is zero
        v = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 32'hABCD_0000, 32'd0, 32'd0};
        run_vec(v, "R4 neg zero");
        check("R4 neg zero literal", result, 32'd0);
        // R8: reserved mode falls back to the plain sum
        v = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 32'd4, 32'd5, 32'd6};
        run_vec(v, "R8 reserved mode");
        check("R8 reserved literal", result, 32'd15);
        check("R8 illegal literal", {31'd0, illegal}, 32'd1);
        // R9: wrap around
        v = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd2, 32'd0};
        run_vec(v, "R9 wrap");
        check("R9 wrap literal", result, 32'd1);

        // R2: idle cycles hold result and drop out_valid
        held = result;
        @(negedge clk);
        op_a = 32'h5555_5555; instr = mk_instr(2'd3, 2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R2 idle out_valid", {31'd0, out_valid}, 32'd0);
        check("R2 idle result hold", result, held);
        check("R2 idle illegal hold", {31'd0, illegal}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule